// File: doc/BRIEF.md
# UART Host-Side FIFO Data Path

This block sits between a processor's data register and the serial engines of a UART. Byte writes go into a transmit queue, and the queue offers them one at a time to the bit-level transmitter through a valid/ready handshake. Each character the receiver delivers is queued together with its parity and framing flags. A register read pops the oldest character and returns an 11-bit word. That word also carries a single overrun flag. The flag is kept outside the queue, and the same read that reports it also clears it.

A level input called `fifoEn` chooses the operating mode for both directions. When it is high, each direction is a `DEPTH`-entry queue. When it is low, each direction is a single-entry holding buffer. Any change of `fifoEn` empties both directions. Status outputs report that the transmit queue is full, that the receive queue is empty, and that the transmit side has a byte pending. These outputs feed a flags register elsewhere.

Top module: `uart_host_fifo`

## Requirements
- R1: After reset, `rdData` is 0, `rxEmpty` is 1, and `txFull`, `txValid` and `txBusy` are 0.
- R2: With `fifoEn` high, the transmit queue accepts `DEPTH` (16) writes. `txFull` rises after the last of them, and the bytes leave on `txData` in the order they were written.
- R3: A write while `txFull` is high is dropped, and the queued bytes are unchanged.
- R4: With `fifoEn` low, the transmit side holds one byte, so `txFull` rises after a single write.
- R5: A write starts transmission. In the cycle after the write, `txValid` and `txBusy` are high with the byte on `txData`. A byte leaves the queue on each edge where `txValid` and `txReady` are both high.
- R6: Every receive strobe (`rxValid`) queues `rxData` with its flags. A read returns the oldest entry with the data in bits 7:0, the framing flag in bit 8 and the parity flag in bit 9. Entries come out in arrival order.
- R7: A character that arrives while the receive side is full is discarded, the stored entries are kept, and the overrun flag is set.
- R8: The overrun flag appears in bit 10 of the next read, and that read clears it. A later read shows bit 10 as 0 unless another overrun has happened.
- R9: A read while `rxEmpty` is high leaves bits 9:0 of `rdData` at the last popped entry, and the receive side stays empty.
- R10: With `fifoEn` low, the receive side holds one character. A second arrival before a read is an overrun.
- R11: Any change of `fifoEn` empties both directions, so `rxEmpty` is 1 and `txValid` is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1: queue mode, 0: single-entry buffers |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Byte written |
| rdEn | input | 1 | Register read strobe |
| rdData | output | DATA_W+3 | Registered read word {overrun, parity, framing, data} |
| txValid | output | 1 | Byte available to the transmitter |
| txData | output | DATA_W | Byte offered to the transmitter |
| txReady | input | 1 | Transmitter accepts the offered byte |
| rxValid | input | 1 | Receiver delivers a character |
| rxData | input | DATA_W | Received byte |
| rxParErr | input | 1 | Parity error on this character |
| rxFrmErr | input | 1 | Framing error on this character |
| txFull | output | 1 | Transmit side cannot take a write |
| rxEmpty | output | 1 | No character waiting |
| txBusy | output | 1 | Transmit side holds a pending byte |

## Verification
The bench keeps the default `DEPTH` of 16 and `DATA_W` of 8. With these values, filling either queue and then pushing one entry past full takes only a few dozen cycles, so the overflow, overrun and drop paths are all reached quickly. The same build is used for bypass mode. In that mode the limit is one entry, so the depth-one full condition, the overrun it causes, and the flush on each mode change are checked with the same pointers.

// File: rtl/uart_host_pkg.sv
`timescale 1ns/1ps
package uart_host_pkg;
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
    logic rdCapture;
  } strobe_t;
endpackage

// File: rtl/uart_host_ring.sv
`timescale 1ns/1ps
module uart_host_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         flush,
  input  logic [WIDTH-1:0]             pushData,
  output logic [WIDTH-1:0]             headData,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign count    = cnt;
endmodule

// File: rtl/uart_host_dp.sv
`timescale 1ns/1ps
module uart_host_dp
  import uart_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      st,
  input  logic                         ovrIn,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [DATA_W-1:0]            rxData,
  input  logic                         rxParErr,
  input  logic                         rxFrmErr,
  output logic [DATA_W-1:0]            txData,
  output logic [DATA_W+2:0]            rdData,
  output logic [$clog2(DEPTH+1)-1:0]   txCount,
  output logic [$clog2(DEPTH+1)-1:0]   rxCount
);
  localparam int RX_W = DATA_W + 2;

  logic [RX_W-1:0]   rxHead;
  logic [DATA_W+2:0] rdQ;

  uart_host_ring #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txRing (
    .clk(clk), .rstN(rstN), .push(st.txPush), .pop(st.txPop), .flush(st.flush),
    .pushData(wrData), .headData(txData), .count(txCount));

  uart_host_ring #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rxRing (
    .clk(clk), .rstN(rstN), .push(st.rxPush), .pop(st.rxPop), .flush(st.flush),
    .pushData({rxParErr, rxFrmErr, rxData}), .headData(rxHead), .count(rxCount));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (st.rdCapture) begin
      rdQ[DATA_W+2] <= ovrIn;
      if (st.rxPop) rdQ[RX_W-1:0] <= rxHead;
    end
  end

  assign rdData = rdQ;
endmodule

// File: rtl/uart_host_ctrl.sv
`timescale 1ns/1ps
module uart_host_ctrl
  import uart_host_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fifoEn,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic                         rxValid,
  input  logic                         txReady,
  input  logic [$clog2(DEPTH+1)-1:0]   txCount,
  input  logic [$clog2(DEPTH+1)-1:0]   rxCount,
  output strobe_t                      st,
  output logic                         ovrFlag,
  output logic                         txFull,
  output logic                         rxEmpty,
  output logic                         txValid
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic             fifoEnQ, ovrQ, flush, rxFull;
  logic [CNT_W-1:0] limit;

  assign flush   = (fifoEn != fifoEnQ);
  assign limit   = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign txFull  = (txCount >= limit);
  assign rxFull  = (rxCount >= limit);
  assign rxEmpty = (rxCount == '0);
  assign txValid = (txCount != '0) && !flush;

  always_comb begin
    st.flush     = flush;
    st.txPush    = wrEn && !txFull && !flush;
    st.txPop     = txValid && txReady;
    st.rxPush    = rxValid && !rxFull && !flush;
    st.rxPop     = rdEn && !rxEmpty && !flush;
    st.rdCapture = rdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEnQ <= 1'b0;
      ovrQ    <= 1'b0;
    end else begin
      fifoEnQ <= fifoEn;
      if (rxValid && rxFull && !flush) ovrQ <= 1'b1;
      else if (rdEn)                   ovrQ <= 1'b0;
    end
  end

  assign ovrFlag = ovrQ;
endmodule

// File: rtl/uart_host_fifo.sv
`timescale 1ns/1ps
module uart_host_fifo
  import uart_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W+2:0] rdData,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  output logic              txFull,
  output logic              rxEmpty,
  output logic              txBusy
);
  localparam int CNT_W = $clog2(DEPTH+1);

  strobe_t          st;
  logic             ovrFlag;
  logic [CNT_W-1:0] txCount, rxCount;

  uart_host_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrEn(wrEn), .rdEn(rdEn),
    .rxValid(rxValid), .txReady(txReady), .txCount(txCount), .rxCount(rxCount),
    .st(st), .ovrFlag(ovrFlag), .txFull(txFull), .rxEmpty(rxEmpty), .txValid(txValid));

  uart_host_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .ovrIn(ovrFlag), .wrData(wrData),
    .rxData(rxData), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr),
    .txData(txData), .rdData(rdData), .txCount(txCount), .rxCount(rxCount));

  assign txBusy = txValid;
endmodule

// File: rtl/uart_host_chk.sv
`timescale 1ns/1ps
module uart_host_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       fifoEn,
  input logic                       wrEn,
  input logic                       rdEn,
  input logic                       rxValid,
  input logic                       txValid,
  input logic                       txReady,
  input logic                       txFull,
  input logic                       rxEmpty,
  input logic                       ovrFlag,
  input logic [DATA_W+2:0]          rdData,
  input logic [$clog2(DEPTH+1)-1:0] txCount,
  input logic [$clog2(DEPTH+1)-1:0] rxCount
);
  localparam int CNT_W = $clog2(DEPTH+1);

  assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(DEPTH));

  assert_rx_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && wrEn && !(txValid && txReady) && fifoEn == $past(fifoEn)) |=> $stable(txCount));

  assert_bypass_depth_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && !$past(fifoEn)) |-> (txCount <= CNT_W'(1) && rxCount <= CNT_W'(1)));

  assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rdEn && fifoEn && $past(fifoEn) && rxCount == CNT_W'(DEPTH))
      |=> (ovrFlag && rxCount == CNT_W'(DEPTH)));

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rxValid) |=> !ovrFlag);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rxEmpty) |=> (rdData[DATA_W+1:0] == $past(rdData[DATA_W+1:0])));
endmodule

bind uart_host_fifo uart_host_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrEn(wrEn), .rdEn(rdEn),
  .rxValid(rxValid), .txValid(txValid), .txReady(txReady), .txFull(txFull),
  .rxEmpty(rxEmpty), .ovrFlag(ovrFlag), .rdData(rdData),
  .txCount(txCount), .rxCount(rxCount));

// File: tb/tb_uart_host_fifo.sv
`timescale 1ns/1ps
module tb_uart_host_fifo;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int NVEC   = 6;
  localparam logic [9:0] RX_VEC [NVEC] = '{10'h0A5, 10'h15A, 10'h2C3, 10'h33C, 10'h000, 10'h3FF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0, txReady = 1'b0, rxValid = 1'b0;
  logic rxParErr = 1'b0, rxFrmErr = 1'b0;
  logic [7:0] wrData = '0, rxData = '0, txData;
  logic [10:0] rdData;
  logic txValid, txFull, rxEmpty, txBusy;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_host_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .txValid(txValid), .txData(txData),
    .txReady(txReady), .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .txFull(txFull), .rxEmpty(rxEmpty), .txBusy(txBusy));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk); wrEn = 1'b1; wrData = b;
    step(); wrEn = 1'b0;
  endtask

  task automatic recvChar(input logic [9:0] e);
    @(negedge clk); rxValid = 1'b1; {rxParErr, rxFrmErr, rxData} = e;
    step(); rxValid = 1'b0;
  endtask

  task automatic readWord();
    @(negedge clk); rdEn = 1'b1;
    step(); rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1'b1;
    idle(3);
    // R1 reset state
    check(rdData == 11'h0, "R1 rdData", rdData, 0);
    check(rxEmpty == 1'b1, "R1 rxEmpty", rxEmpty, 1);
    check(txFull == 1'b0 && txValid == 1'b0 && txBusy == 1'b0, "R1 tx flags",
          {txFull, txValid, txBusy}, 0);

    // R5 write starts transmission
    writeByte(8'h10);
    check(txValid && txBusy, "R5 txValid/txBusy after write", {txValid, txBusy}, 3);
    check(txData == 8'h10, "R5 txData", txData, 8'h10);

    // R2 fill to 16
    for (int i = 1; i < DEPTH; i++) begin
      check(!txFull, "R2 not full early", txFull, 0);
      writeByte(8'h10 + 8'(i));
    end
    check(txFull, "R2 txFull at depth", txFull, 1);
    // R3 write when full dropped
    writeByte(8'hEE);
    // drain, order checked
    @(negedge clk); txReady = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      check(txValid && txData == 8'h10 + 8'(i), "R2/R3 drain order", txData, 8'h10 + i);
      @(posedge clk); @(negedge clk);
    end
    check(!txValid && !txBusy, "R3 dropped write not queued", txValid, 0);
    txReady = 1'b0;

    // R6 table-driven receive path
    for (int i = 0; i < NVEC; i++) recvChar(RX_VEC[i]);
    check(!rxEmpty, "R6 rxEmpty after pushes", rxEmpty, 0);
    for (int i = 0; i < NVEC; i++) begin
      readWord();
      check(rdData == {1'b0, RX_VEC[i]}, "R6 read word", rdData, {1'b0, RX_VEC[i]});
    end
    check(rxEmpty, "R6 empty after reads", rxEmpty, 1);

    // R9 empty read keeps last entry
    readWord();
    check(rdData == {1'b0, RX_VEC[NVEC-1]}, "R9 empty read", rdData, {1'b0, RX_VEC[NVEC-1]});
    check(rxEmpty, "R9 still empty", rxEmpty, 1);

    // R7/R8 overrun in queue mode
    for (int i = 0; i <= DEPTH; i++) recvChar(10'(8'h40 + i));
    readWord();
    check(rdData == {1'b1, 2'b00, 8'h40}, "R7/R8 first read with overrun", rdData, {1'b1, 2'b00, 8'h40});
    readWord();
    check(rdData == {1'b0, 2'b00, 8'h41}, "R8 overrun cleared", rdData, {1'b0, 2'b00, 8'h41});
    for (int i = 2; i < DEPTH; i++) readWord();
    check(rdData == {1'b0, 2'b00, 8'h4F}, "R7 last kept entry", rdData, {1'b0, 2'b00, 8'h4F});
    check(rxEmpty, "R7 extra char discarded", rxEmpty, 1);

    // R11 flush on mode change
    recvChar(10'h011); recvChar(10'h022);
    txReady = 1'b0;
    writeByte(8'h31); writeByte(8'h32);
    @(negedge clk); fifoEn = 1'b0;
    step(); step();
    check(rxEmpty && !txValid, "R11 flush on disable", {rxEmpty, txValid}, 2);

    // R4 bypass transmit
    writeByte(8'hA1);
    check(txFull && txData == 8'hA1, "R4 one-byte full", {txFull, txData}, {1'b1, 8'hA1});
    writeByte(8'hA2);
    check(txData == 8'hA1, "R4 second write dropped", txData, 8'hA1);
    @(negedge clk); txReady = 1'b1;
    step(); txReady = 1'b0;
    check(!txValid && !txFull, "R4 empty after send", {txValid, txFull}, 0);

    // R10 bypass receive overrun
    recvChar(10'h155); recvChar(10'h066);
    readWord();
    check(rdData == {1'b1, 10'h155}, "R10 bypass overrun", rdData, {1'b1, 10'h155});
    check(rxEmpty, "R10 second char discarded", rxEmpty, 1);

    // R11 flush on enable
    recvChar(10'h077); writeByte(8'h55);
    @(negedge clk); fifoEn = 1'b1;
    step(); step();
    check(rxEmpty && !txValid, "R11 flush on enable", {rxEmpty, txValid}, 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule